// File: doc/BRIEF.md
# Local/Nonlocal Address Mapping Switch

This block sits between one processor and the rest of its computer module. Every processor memory reference is classified through a small mapping table. The table index joins a one-bit mode flag from the processor status word with the top address bits. A reference whose entry is marked local goes straight to local memory and I/O in the same cycle. A reference whose entry is marked nonlocal is turned into a service request toward a shared map bus. That request carries a virtual address made of the entry's remote address field with this processor's identifier appended. The processor is held off with a wait signal until the reply comes back.

The switch also serves references that arrive from other modules and want this module's local memory. When such an access meets a local processor access in the same cycle, the processor goes first and the remote access is served in the following cycle, ahead of anything else. A reference that lands on an invalid table entry raises a fault pulse and goes nowhere. The map-bus side is a plain request/acknowledge handshake followed by a reply strobe. Software fills the table through a write-only configuration port.

Top module: `addr_map_switch`

## Requirements
- R1: The table index is `{psw_mode, cpu_addr[ADDR_W-1:ADDR_W-4]}` (mode bit on top), giving 32 entries. A `cfg_we` pulse writes `cfg_valid`, `cfg_local` and `cfg_nla` into entry `cfg_idx`, and the new contents steer lookups from the next cycle on.
- R2: After reset every entry is invalid and `lm_req`, `mb_req`, `rm_ack` and `cpu_fault` are low.
- R3: A request that hits a valid entry with local flag 1 drives `lm_req=1` with `lm_addr`, `lm_we` and `lm_wdata` equal to the processor's in the same cycle. In that cycle `cpu_wait=0` and `cpu_rdata=lm_rdata`.
- R4: A request that hits a valid entry with local flag 0 raises `mb_req` from the next cycle on and holds it until a cycle with `mb_ack=1`. While it is held, `mb_vaddr = {entry nla, PROC_ID}` (identifier in the low bits), `mb_off` is the low 12 address bits, and `mb_we`/`mb_wdata` follow the processor.
- R5: During a nonlocal reference `cpu_wait` stays high from the request cycle until the reply. In the cycle after `mb_rvalid=1`, `cpu_wait=0` and `cpu_rdata` equals the `mb_rdata` that came with the strobe.
- R6: A request that hits an invalid entry pulses `cpu_fault` with `cpu_wait=0`. No `lm_req` is driven for it and no `mb_req` follows.
- R7: A remote access (`rm_req`) with no competing processor local access is acknowledged with `rm_ack=1` in the same cycle. It drives local memory with `rm_addr`, `rm_we` and `rm_wdata`, and `rm_rdata=lm_rdata`.
- R8: When a remote access and a processor local access arrive in the same cycle, the processor is served and `rm_ack` stays low. In the next cycle the remote access is acknowledged, and a processor local request in that cycle sees `cpu_wait=1`.
- R9: The same address with `psw_mode` 0 and 1 reads two different table entries.
- R10: A remote access is served while the processor is stalled on a nonlocal reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 5 | Entry to write |
| cfg_valid | input | 1 | Valid bit written |
| cfg_local | input | 1 | Local flag written |
| cfg_nla | input | NLA_W | Remote address field written |
| cpu_req | input | 1 | Processor reference request (held until wait drops) |
| cpu_we | input | 1 | Processor write |
| psw_mode | input | 1 | Mode bit from the status word |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data to processor |
| cpu_wait | output | 1 | Not-ready stall |
| cpu_fault | output | 1 | Invalid-entry fault pulse |
| lm_req | output | 1 | Local memory/I/O access |
| lm_we | output | 1 | Local write |
| lm_addr | output | ADDR_W | Local address |
| lm_wdata | output | DATA_W | Local write data |
| lm_rdata | input | DATA_W | Local read data (same cycle) |
| rm_req | input | 1 | Incoming remote access (held until acknowledged) |
| rm_we | input | 1 | Remote write |
| rm_addr | input | ADDR_W | Remote address into this module |
| rm_wdata | input | DATA_W | Remote write data |
| rm_rdata | output | DATA_W | Read data to remote requester |
| rm_ack | output | 1 | Remote access served this cycle |
| mb_req | output | 1 | Map-bus service request |
| mb_ack | input | 1 | Request accepted |
| mb_vaddr | output | NLA_W+PID_W | Virtual address: remote field then processor identifier |
| mb_off | output | 12 | Offset within the remote page |
| mb_we | output | 1 | Nonlocal write |
| mb_wdata | output | DATA_W | Nonlocal write data |
| mb_rvalid | input | 1 | Reply strobe |
| mb_rdata | input | DATA_W | Reply data |

## Verification
The bench uses the default 16-bit address and data with a 12-bit remote field, and sets PROC_ID to 6. With that setting the identifier shows up as a nonzero pattern in the low nibble of the virtual address. Entries are placed in both mode halves at the same address tag, so the mode bit's share of the index is observable. The map-bus handshake is stretched with a withheld acknowledge, which makes request holding visible. A remote access is injected during the reply wait, and another in the same cycle as a local access, so that both the priority rule and the one-cycle deferral can be seen.

// File: rtl/amap_pkg.sv
package amap_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_DONE = 2'd3
  } fetch_state_t;
endpackage

// File: rtl/amap_table.sv
module amap_table #(
  parameter int IDX_W = 5,
  parameter int NLA_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_local,
  input  logic [NLA_W-1:0] wr_nla,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_local,
  output logic [NLA_W-1:0] rd_nla
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] v_q;
  logic [ENTRIES-1:0] l_q;
  logic [NLA_W-1:0]   n_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[e] <= 1'b0;
        l_q[e] <= 1'b0;
        n_q[e] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        v_q[e] <= wr_valid;
        l_q[e] <= wr_local;
        n_q[e] <= wr_nla;
      end
    end
  end

  assign rd_valid = v_q[rd_idx];
  assign rd_local = l_q[rd_idx];
  assign rd_nla   = n_q[rd_idx];

  // R1: a written entry is readable with the written valid bit next cycle
  p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> v_q[$past(wr_idx)] == $past(wr_valid));
endmodule

// File: rtl/amap_fetch.sv
module amap_fetch
  import amap_pkg::*;
#(
  parameter int               OFF_W   = 12,
  parameter int               NLA_W   = 12,
  parameter int               PID_W   = 4,
  parameter int               DATA_W  = 16,
  parameter logic [PID_W-1:0] PROC_ID = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch,
  input  logic [NLA_W-1:0]       launch_nla,
  input  logic [OFF_W-1:0]       launch_off,
  input  logic                   launch_we,
  input  logic [DATA_W-1:0]      launch_wdata,
  input  logic                   mb_ack,
  input  logic                   mb_rvalid,
  input  logic [DATA_W-1:0]      mb_rdata,
  output logic                   busy,
  output logic                   done,
  output logic                   mb_req,
  output logic [NLA_W+PID_W-1:0] mb_vaddr,
  output logic [OFF_W-1:0]       mb_off,
  output logic                   mb_we,
  output logic [DATA_W-1:0]      mb_wdata,
  output logic [DATA_W-1:0]      rdata
);
  localparam int VA_W = NLA_W + PID_W;

  fetch_state_t st_q;

  function automatic logic [VA_W-1:0] form_vaddr(input logic [NLA_W-1:0] nla);
    return {nla, PROC_ID};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FS_IDLE;
      mb_vaddr <= '0;
      mb_off   <= '0;
      mb_we    <= 1'b0;
      mb_wdata <= '0;
      rdata    <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (launch) begin
          st_q     <= FS_REQ;
          mb_vaddr <= form_vaddr(launch_nla);
          mb_off   <= launch_off;
          mb_we    <= launch_we;
          mb_wdata <= launch_wdata;
        end
        FS_REQ:  if (mb_ack) st_q <= FS_WAIT;
        FS_WAIT: if (mb_rvalid) begin
          st_q  <= FS_DONE;
          rdata <= mb_rdata;
        end
        FS_DONE: st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign mb_req = (st_q == FS_REQ);
  assign busy   = (st_q != FS_IDLE);
  assign done   = (st_q == FS_DONE);

  // R4: an unanswered request stays up with a steady virtual address
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req && !mb_ack |=> mb_req && $stable(mb_vaddr) && $stable(mb_off));
  // R5: the reply is handed over exactly one cycle after the strobe
  p_reply_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mb_req && !done && mb_rvalid |=> done);
endmodule

// File: rtl/amap_port_arb.sv
module amap_port_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_want,
  input  logic rm_req,
  output logic cpu_go,
  output logic rm_ack
);
  logic rm_pend_q;
  logic collide;

  assign collide = cpu_want && rm_req;
  assign rm_ack  = rm_req && (rm_pend_q || !cpu_want);
  assign cpu_go  = cpu_want && !(rm_pend_q && rm_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rm_pend_q <= 1'b0;
    else        rm_pend_q <= rm_req && !rm_ack;
  end

  // R8: local memory has at most one owner in any cycle
  p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_go, rm_ack}));
  // R8: a deferred remote access waits no more than one cycle
  p_defer_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rm_req && !rm_ack |=> !rm_req || rm_ack);
  // R8: in a collision the processor is the one served
  p_cpu_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    collide && !rm_pend_q |-> cpu_go);
endmodule

// File: rtl/addr_map_switch.sv
module addr_map_switch #(
  parameter int                 ADDR_W  = 16,
  parameter int                 DATA_W  = 16,
  parameter int                 NLA_W   = 12,
  parameter int                 PID_W   = 4,
  parameter int                 TAG_W   = 4,
  parameter logic [PID_W-1:0]   PROC_ID = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [TAG_W:0]          cfg_idx,
  input  logic                    cfg_valid,
  input  logic                    cfg_local,
  input  logic [NLA_W-1:0]        cfg_nla,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic                    psw_mode,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_wait,
  output logic                    cpu_fault,
  output logic                    lm_req,
  output logic                    lm_we,
  output logic [ADDR_W-1:0]       lm_addr,
  output logic [DATA_W-1:0]       lm_wdata,
  input  logic [DATA_W-1:0]       lm_rdata,
  input  logic                    rm_req,
  input  logic                    rm_we,
  input  logic [ADDR_W-1:0]       rm_addr,
  input  logic [DATA_W-1:0]       rm_wdata,
  output logic [DATA_W-1:0]       rm_rdata,
  output logic                    rm_ack,
  output logic                    mb_req,
  input  logic                    mb_ack,
  output logic [NLA_W+PID_W-1:0]  mb_vaddr,
  output logic [ADDR_W-TAG_W-1:0] mb_off,
  output logic                    mb_we,
  output logic [DATA_W-1:0]       mb_wdata,
  input  logic                    mb_rvalid,
  input  logic [DATA_W-1:0]       mb_rdata
);
  localparam int IDX_W = TAG_W + 1;
  localparam int OFF_W = ADDR_W - TAG_W;

  function automatic logic [IDX_W-1:0] make_index(input logic mode,
                                                  input logic [ADDR_W-1:0] a);
    return {mode, a[ADDR_W-1 -: TAG_W]};
  endfunction

  logic [IDX_W-1:0]  look_idx;
  logic              ent_valid, ent_local;
  logic [NLA_W-1:0]  ent_nla;
  logic              f_busy, f_done;
  logic [DATA_W-1:0] f_rdata;
  logic              lookup_en, want_local, launch_nl, cpu_go;

  assign look_idx = make_index(psw_mode, cpu_addr);

  amap_table #(.IDX_W(IDX_W), .NLA_W(NLA_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid),
    .wr_local(cfg_local), .wr_nla(cfg_nla),
    .rd_idx(look_idx), .rd_valid(ent_valid), .rd_local(ent_local), .rd_nla(ent_nla)
  );

  // Lookup events, named for the checks below
  assign lookup_en  = cpu_req && !f_busy;
  assign want_local = lookup_en && ent_valid && ent_local;
  assign launch_nl  = lookup_en && ent_valid && !ent_local;
  assign cpu_fault  = lookup_en && !ent_valid;

  amap_fetch #(.OFF_W(OFF_W), .NLA_W(NLA_W), .PID_W(PID_W), .DATA_W(DATA_W),
               .PROC_ID(PROC_ID)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .launch(launch_nl), .launch_nla(ent_nla), .launch_off(cpu_addr[OFF_W-1:0]),
    .launch_we(cpu_we), .launch_wdata(cpu_wdata),
    .mb_ack(mb_ack), .mb_rvalid(mb_rvalid), .mb_rdata(mb_rdata),
    .busy(f_busy), .done(f_done),
    .mb_req(mb_req), .mb_vaddr(mb_vaddr), .mb_off(mb_off),
    .mb_we(mb_we), .mb_wdata(mb_wdata), .rdata(f_rdata)
  );

  amap_port_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .cpu_want(want_local), .rm_req(rm_req),
    .cpu_go(cpu_go), .rm_ack(rm_ack)
  );

  assign lm_req   = cpu_go || rm_ack;
  assign lm_we    = rm_ack ? rm_we    : (cpu_go && cpu_we);
  assign lm_addr  = rm_ack ? rm_addr  : cpu_addr;
  assign lm_wdata = rm_ack ? rm_wdata : cpu_wdata;
  assign rm_rdata = lm_rdata;

  assign cpu_wait  = cpu_req && !(cpu_go || cpu_fault || f_done);
  assign cpu_rdata = f_done ? f_rdata : lm_rdata;

  // R6: a faulting reference reaches neither local memory nor the map bus
  p_fault_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fault |-> !lm_req || rm_ack);
  p_fault_remote_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fault |=> !mb_req);
  // R5: the processor stays stalled while a nonlocal reference is outstanding
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && f_busy && !f_done |-> cpu_wait);
  // R3: a completed local reference leaves the stall low
  p_local_nowait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lm_req && !rm_ack |-> !cpu_wait);
endmodule

// File: tb/addr_map_switch_tb.sv
module addr_map_switch_tb;
  localparam int AW = 16, DW = 16, NW = 12, PW = 4;
  localparam logic [PW-1:0] PID = 4'h6;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic cfg_we = 0, cfg_valid = 0, cfg_local = 0;
  logic [4:0] cfg_idx = '0;
  logic [NW-1:0] cfg_nla = '0;
  logic cpu_req = 0, cpu_we = 0, psw_mode = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_wait, cpu_fault, lm_req, lm_we;
  logic [AW-1:0] lm_addr;
  logic [DW-1:0] lm_wdata, lm_rdata;
  logic rm_req = 0, rm_we = 0, rm_ack;
  logic [AW-1:0] rm_addr = '0;
  logic [DW-1:0] rm_wdata = '0, rm_rdata;
  logic mb_req, mb_ack = 0, mb_we, mb_rvalid = 0;
  logic [NW+PW-1:0] mb_vaddr;
  logic [11:0] mb_off;
  logic [DW-1:0] mb_wdata, mb_rdata = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  assign lm_rdata = lm_addr ^ 16'h3C3C;

  addr_map_switch #(.PROC_ID(PID)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask
  task automatic at_neg(); @(negedge clk); endtask

  task automatic put_entry(input logic [4:0] idx, input logic v, input logic l,
                           input logic [NW-1:0] nla);
    cfg_we = 1; cfg_idx = idx; cfg_valid = v; cfg_local = l; cfg_nla = nla;
    step();
    cfg_we = 0;
  endtask

  task automatic t_reset();
    at_neg();
    chk("R2 lm_req", lm_req, 0);
    chk("R2 mb_req", mb_req, 0);
    chk("R2 rm_ack", rm_ack, 0);
    chk("R2 fault", cpu_fault, 0);
    // every entry invalid after reset: a request faults
    step(); cpu_req = 1; cpu_addr = 16'h7123; psw_mode = 1;
    at_neg();
    chk("R2 invalid after reset", cpu_fault, 1);
    step(); cpu_req = 0;
  endtask

  task automatic t_local();
    put_entry(5'h03, 1, 1, 12'h000);      // mode 0, tag 3
    cpu_req = 1; cpu_we = 1; psw_mode = 0; cpu_addr = 16'h3456; cpu_wdata = 16'hBEEF;
    at_neg();
    chk("R3 lm_req", lm_req, 1);
    chk("R3 lm_addr", lm_addr, 16'h3456);
    chk("R3 lm_we", lm_we, 1);
    chk("R3 lm_wdata", lm_wdata, 16'hBEEF);
    chk("R3 wait", cpu_wait, 0);
    step(); cpu_we = 0; cpu_addr = 16'h3001;
    at_neg();
    chk("R3 rdata", cpu_rdata, 16'h3001 ^ 16'h3C3C);
    chk("R1 lookup uses new entry", lm_req, 1);
    step(); cpu_req = 0;
  endtask

  task automatic t_fault();
    put_entry(5'h05, 0, 1, 12'h000);
    cpu_req = 1; psw_mode = 0; cpu_addr = 16'h5000;
    at_neg();
    chk("R6 fault", cpu_fault, 1);
    chk("R6 no lm_req", lm_req, 0);
    chk("R6 wait", cpu_wait, 0);
    step(); cpu_req = 0;
    at_neg();
    chk("R6 no mb_req", mb_req, 0);
    chk("R6 fault drops", cpu_fault, 0);
  endtask

  task automatic t_nonlocal(input logic mode, input logic [AW-1:0] a,
                            input logic [NW-1:0] nla, input logic [DW-1:0] rd,
                            input bit remote_mid);
    cpu_req = 1; cpu_we = 1; cpu_wdata = 16'h1357; psw_mode = mode; cpu_addr = a;
    at_neg();
    chk("R5 wait at request", cpu_wait, 1);
    chk("R4 no req yet", mb_req, 0);
    chk("R4 no local", lm_req, 0);
    step();
    at_neg();
    chk("R4 mb_req", mb_req, 1);
    chk("R4 vaddr", mb_vaddr, {nla, PID});
    chk("R4 off", mb_off, a[11:0]);
    chk("R4 we", mb_we, 1);
    chk("R4 wdata", mb_wdata, 16'h1357);
    step();                              // ack withheld
    at_neg();
    chk("R4 held", mb_req, 1);
    chk("R5 wait held", cpu_wait, 1);
    mb_ack = 1; step(); mb_ack = 0;
    at_neg();
    chk("R4 drops after ack", mb_req, 0);
    chk("R5 wait in reply wait", cpu_wait, 1);
    if (remote_mid) begin
      step(); rm_req = 1; rm_we = 0; rm_addr = 16'h0ABC;
      at_neg();
      chk("R10 remote ack", rm_ack, 1);
      chk("R10 remote addr", lm_addr, 16'h0ABC);
      chk("R10 remote rdata", rm_rdata, 16'h0ABC ^ 16'h3C3C);
      step(); rm_req = 0;
    end
    mb_rvalid = 1; mb_rdata = rd; step(); mb_rvalid = 0; mb_rdata = '0;
    at_neg();
    chk("R5 wait low", cpu_wait, 0);
    chk("R5 rdata", cpu_rdata, rd);
    step(); cpu_req = 0; cpu_we = 0;
  endtask

  task automatic t_mode_split();
    put_entry(5'h09, 1, 0, 12'hA5C);     // mode 0, tag 9: nonlocal
    put_entry(5'h19, 1, 1, 12'h000);     // mode 1, tag 9: local
    cpu_req = 1; psw_mode = 1; cpu_addr = 16'h9111;
    at_neg();
    chk("R9 mode1 local", lm_req, 1);
    step(); cpu_req = 0;
    at_neg();
    chk("R9 mode1 no mb_req", mb_req, 0);
    step();
    t_nonlocal(0, 16'h9222, 12'hA5C, 16'hC0DE, 0);   // R9 mode0 nonlocal
  endtask

  task automatic t_remote_alone();
    rm_req = 1; rm_we = 1; rm_addr = 16'h2222; rm_wdata = 16'h4444;
    at_neg();
    chk("R7 ack", rm_ack, 1);
    chk("R7 addr", lm_addr, 16'h2222);
    chk("R7 we", lm_we, 1);
    chk("R7 wdata", lm_wdata, 16'h4444);
    step(); rm_req = 0; rm_we = 0;
  endtask

  task automatic t_collision();
    cpu_req = 1; psw_mode = 0; cpu_addr = 16'h3100;
    rm_req = 1; rm_addr = 16'h0777;
    at_neg();
    chk("R8 cpu first addr", lm_addr, 16'h3100);
    chk("R8 cpu no wait", cpu_wait, 0);
    chk("R8 remote deferred", rm_ack, 0);
    step(); cpu_addr = 16'h3200;
    at_neg();
    chk("R8 remote next", rm_ack, 1);
    chk("R8 remote addr", lm_addr, 16'h0777);
    chk("R8 cpu stalled", cpu_wait, 1);
    step(); rm_req = 0;
    at_neg();
    chk("R8 cpu resumes", lm_addr, 16'h3200);
    chk("R8 cpu no wait after", cpu_wait, 0);
    step(); cpu_req = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_local();
    t_fault();
    put_entry(5'h1C, 1, 0, 12'h3E1);
    t_nonlocal(1, 16'hC0F4, 12'h3E1, 16'h9A9A, 1);
    t_mode_split();
    t_remote_alone();
    t_collision();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule